// File: doc/BRIEF.md
# Program Address Ring Stack

This block holds the live program address of a small processor together with its saved return addresses. It is a ring of eight 14-bit entries plus a 3-bit pointer. The entry under the pointer is the program address shown on `pc_o`. The other seven entries hold return levels. Calls and restarts move the pointer forward one place and write the new address there, which leaves the caller's address untouched one place behind. Returns move the pointer back one place. No data is ever copied between entries.

An instruction sequencer drives one operation per clock on `op_i`. `op_i` is a plain control pin that takes effect on every rising edge. It has no valid/ready handshake, so the block never applies back-pressure. When `guard_i` is set, a jump, call or return first tests a condition built from `cond_i` and the four flag inputs. If the test fails, the address only advances by one. The value that a call saves is the current `pc_o`. The sequencer is expected to have already stepped it past the calling instruction.

Top module: `prog_addr_stack`

## Requirements
- R1: While `rst_n` is low, every entry and the pointer clear on the clock edge, so `pc_o` is 0 one cycle later.
- R2: Op code 1 (step) adds one to `pc_o`, and 3FFFh wraps to 0000h.
- R3: Op codes 0, 6 and 7 (hold) leave `pc_o` and the whole stack unchanged.
- R4: Op code 2 (jump) loads `target_i` into `pc_o` and leaves the saved levels alone.
- R5: Op code 3 (call) keeps the current `pc_o` as a return level and loads `target_i`.
- R6: Op code 4 (return) brings back the most recently saved address, in last-in first-out order, for up to seven nested levels.
- R7: Op code 5 (restart) saves `pc_o` like a call and loads `vec_i` × 8, which gives 00h, 08h, … 38h. It ignores `guard_i`.
- R8: The condition holds when `flags_i[cond_i[1:0]] == cond_i[2]`. The flag bits are: bit 0 carry, bit 1 zero, bit 2 sign, bit 3 parity (1 means even).
- R9: A guarded jump, call or return whose condition fails only adds one to `pc_o` and leaves the saved levels unchanged.
- R10: The ring wraps silently. An eighth nested call overwrites the oldest level. A return with no matching call moves the pointer backwards around the ring, so right after reset it yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Operation code (see R2–R7) |
| guard_i | input | 1 | Makes jump/call/return conditional |
| cond_i | input | 3 | Bit 2 sense, bits 1:0 flag select |
| flags_i | input | 4 | Carry, zero, sign, parity-even |
| target_i | input | 14 | Jump or call destination |
| vec_i | input | 3 | Restart vector number |
| pc_o | output | 14 | Current program address |

## Verification
The bench builds the block with its default parameters: 14-bit addresses and a 3-bit pointer, which gives eight entries. Because the ring is that small, both overflow and underflow can be reached in a handful of cycles. A nine-deep call chain and an unmatched return right after reset are both directed cases. The full 14-bit width makes the 3FFFh-to-0 wrap reachable with one jump and one step. Random operations with random flags then cover every condition code in both senses, for both taken and not-taken branches.

// File: rtl/pas_pkg.sv
package pas_pkg;
  typedef enum logic [2:0] {
    PAS_HOLD = 3'd0,
    PAS_STEP = 3'd1,
    PAS_JUMP = 3'd2,
    PAS_CALL = 3'd3,
    PAS_RET  = 3'd4,
    PAS_RST  = 3'd5
  } pas_op_e;

  localparam int PAS_FLAG_W = 4;
  localparam int PAS_SEL_W  = 2;
endpackage

// File: rtl/pas_cond.sv
module pas_cond
  import pas_pkg::*;
(
  input  logic [PAS_SEL_W:0]    cond_i,
  input  logic [PAS_FLAG_W-1:0] flags_i,
  output logic                  hit_o
);
  logic picked;
  always_comb begin
    picked = flags_i[cond_i[PAS_SEL_W-1:0]];
    hit_o  = (picked == cond_i[PAS_SEL_W]);
  end
endmodule

// File: rtl/pas_next.sv
module pas_next
  import pas_pkg::*;
#(
  parameter int AW    = 14,
  parameter int VW    = 3,
  parameter int VSHIFT = 3
) (
  input  logic [2:0]    op_i,
  input  logic          taken_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] target_i,
  input  logic [VW-1:0] vec_i,
  output logic          push_o,
  output logic          pop_o,
  output logic          wr_o,
  output logic [AW-1:0] wdata_o
);
  logic [AW-1:0] pc_inc;
  logic [AW-1:0] vec_addr;
  pas_op_e       op;

  always_comb begin
    op       = pas_op_e'(op_i);
    pc_inc   = pc_i + 1'b1;
    vec_addr = AW'({vec_i, {VSHIFT{1'b0}}});
    push_o   = 1'b0;
    pop_o    = 1'b0;
    wr_o     = 1'b0;
    wdata_o  = pc_inc;
    case (op)
      PAS_STEP: wr_o = 1'b1;
      PAS_JUMP: begin
        wr_o    = 1'b1;
        wdata_o = taken_i ? target_i : pc_inc;
      end
      PAS_CALL: begin
        if (taken_i) begin
          push_o  = 1'b1;
          wdata_o = target_i;
        end else begin
          wr_o = 1'b1;
        end
      end
      PAS_RET: begin
        if (taken_i) pop_o = 1'b1;
        else         wr_o  = 1'b1;
      end
      PAS_RST: begin
        push_o  = 1'b1;
        wdata_o = vec_addr;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pas_bank.sv
module pas_bank #(
  parameter int AW = 14,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] top_o
);
  localparam int DEPTH = 1 << LW;

  logic [LW-1:0] ptr;
  logic [LW-1:0] ptr_up;
  logic [LW-1:0] ptr_dn;
  logic [AW-1:0] ent [DEPTH];

  always_comb begin
    ptr_up = ptr + 1'b1;
    ptr_dn = ptr - 1'b1;
    top_o  = ent[ptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (push_i) ptr <= ptr_up;
    else if (pop_i)  ptr <= ptr_dn;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic sel;
    always_comb sel = (push_i && ptr_up == LW'(i)) ||
                      (wr_i && !push_i && !pop_i && ptr == LW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   ent[i] <= '0;
      else if (sel) ent[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/prog_addr_stack.sv
module prog_addr_stack
  import pas_pkg::*;
#(
  parameter int AW     = 14,
  parameter int LW     = 3,
  parameter int VW     = 3,
  parameter int VSHIFT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            op_i,
  input  logic                  guard_i,
  input  logic [PAS_SEL_W:0]    cond_i,
  input  logic [PAS_FLAG_W-1:0] flags_i,
  input  logic [AW-1:0]         target_i,
  input  logic [VW-1:0]         vec_i,
  output logic [AW-1:0]         pc_o
);
  logic          hit;
  logic          taken;
  logic          push;
  logic          pop;
  logic          wr;
  logic [AW-1:0] wdata;
  logic [AW-1:0] top;

  pas_cond u_cond (
    .cond_i  (cond_i),
    .flags_i (flags_i),
    .hit_o   (hit)
  );

  always_comb taken = !guard_i || hit;

  pas_next #(.AW(AW), .VW(VW), .VSHIFT(VSHIFT)) u_next (
    .op_i     (op_i),
    .taken_i  (taken),
    .pc_i     (top),
    .target_i (target_i),
    .vec_i    (vec_i),
    .push_o   (push),
    .pop_o    (pop),
    .wr_o     (wr),
    .wdata_o  (wdata)
  );

  pas_bank #(.AW(AW), .LW(LW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .pop_i   (pop),
    .wr_i    (wr),
    .wdata_i (wdata),
    .top_o   (top)
  );

  assign pc_o = top;
endmodule

// File: rtl/pas_chk.sv
module pas_chk #(
  parameter int AW     = 14,
  parameter int VW     = 3,
  parameter int VSHIFT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op_i,
  input logic          guard_i,
  input logic [2:0]    cond_i,
  input logic [3:0]    flags_i,
  input logic [AW-1:0] target_i,
  input logic [VW-1:0] vec_i,
  input logic [AW-1:0] pc_o
);
  logic cond_true;
  assign cond_true = flags_i[cond_i[1:0]] == cond_i[2];

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> pc_o == '0);

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'd1 |=> pc_o == AW'($past(pc_o) + 1'b1));

  // R3
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0 || op_i >= 3'd6) |=> $stable(pc_o));

  // R4
  jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd2 && !guard_i) |=> pc_o == $past(target_i));

  // R5
  call_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3 && !guard_i) ##1 (op_i == 3'd4 && !guard_i)
      |=> pc_o == $past(pc_o, 2));

  // R7
  restart_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'd5 |=> pc_o == AW'({$past(vec_i), {VSHIFT{1'b0}}}));

  // R9
  skip_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_i && !cond_true && (op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd4))
      |=> pc_o == AW'($past(pc_o) + 1'b1));
endmodule

bind prog_addr_stack pas_chk #(.AW(AW), .VW(VW), .VSHIFT(VSHIFT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_i     (op_i),
  .guard_i  (guard_i),
  .cond_i   (cond_i),
  .flags_i  (flags_i),
  .target_i (target_i),
  .vec_i    (vec_i),
  .pc_o     (pc_o)
);

// File: tb/sim_prog_addr_stack.sv
module sim_prog_addr_stack;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op_i = '0;
  logic          guard_i = 1'b0;
  logic [2:0]    cond_i = '0;
  logic [3:0]    flags_i = '0;
  logic [AW-1:0] target_i = '0;
  logic [2:0]    vec_i = '0;
  logic [AW-1:0] pc_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [AW-1:0] m [8];
  logic [2:0]    mp;

  always #10 clk = ~clk;

  prog_addr_stack u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .guard_i(guard_i), .cond_i(cond_i),
    .flags_i(flags_i), .target_i(target_i), .vec_i(vec_i), .pc_o(pc_o)
  );

  function automatic bit cond_hit(logic [2:0] c, logic [3:0] f);
    return f[c[1:0]] == c[2];
  endfunction

  function automatic string auto_tag(logic [2:0] op, bit g, bit tk);
    if (g && !tk && (op == 3'd2 || op == 3'd3 || op == 3'd4)) return "R9";
    if (g && (op == 3'd2 || op == 3'd3 || op == 3'd4)) return "R8";
    case (op)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string tag, logic [AW-1:0] got, logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: pc_o=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m[i] = '0;
    mp = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_i = 3'd0;
    @(posedge clk); #2;
    model_reset();
    check("R1", pc_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic apply(logic [2:0] op, bit g, logic [2:0] c, logic [3:0] f,
                       logic [AW-1:0] t, logic [2:0] v, string tag);
    bit tk;
    string tg;
    @(negedge clk);
    op_i = op; guard_i = g; cond_i = c; flags_i = f; target_i = t; vec_i = v;
    tk = !g || cond_hit(c, f);
    case (op)
      3'd1: m[mp] = m[mp] + 1'b1;
      3'd2: m[mp] = tk ? t : m[mp] + 1'b1;
      3'd3: if (tk) begin mp = mp + 1'b1; m[mp] = t; end
            else m[mp] = m[mp] + 1'b1;
      3'd4: if (tk) mp = mp - 1'b1;
            else m[mp] = m[mp] + 1'b1;
      3'd5: begin mp = mp + 1'b1; m[mp] = AW'({v, 3'b000}); end
      default: ;
    endcase
    tg = (tag == "") ? auto_tag(op, g, tk) : tag;
    @(posedge clk); #2;
    check(tg, pc_o, m[mp]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0101));
    model_reset();
    do_reset();

    // R2 wrap at the top of the address space
    apply(3'd2, 0, 3'd0, 4'h0, 14'h3FFF, 3'd0, "R4");
    apply(3'd1, 0, 3'd0, 4'h0, 14'h0000, 3'd0, "R2");
    // R3 all hold codes
    apply(3'd6, 0, 3'd0, 4'h0, 14'h1234, 3'd3, "R3");
    apply(3'd7, 0, 3'd0, 4'h0, 14'h2222, 3'd1, "R3");
    apply(3'd0, 0, 3'd0, 4'h0, 14'h0ABC, 3'd2, "R3");
    // R7 highest vector
    apply(3'd5, 0, 3'd0, 4'h0, 14'h0000, 3'd7, "R7");
    apply(3'd4, 0, 3'd0, 4'h0, 14'h0000, 3'd0, "R6");
    // R8 each flag, both senses, through a guarded jump
    for (int k = 0; k < 8; k++) begin
      apply(3'd2, 1, 3'(k), 4'b0101, 14'h0100 + 14'(k), 3'd0, "R8");
      apply(3'd2, 1, 3'(k), 4'b1010, 14'h0200 + 14'(k), 3'd0, "R8");
    end
    // R9 guarded call and return that fail
    apply(3'd3, 1, 3'b100, 4'b0000, 14'h3000, 3'd0, "R9");
    apply(3'd4, 1, 3'b011, 4'b1000, 14'h0000, 3'd0, "R9");

    // R10 underflow straight after reset
    do_reset();
    apply(3'd4, 0, 3'd0, 4'h0, 14'h0000, 3'd0, "R10");
    // R6 / R10 nine-deep nesting, then unwind
    do_reset();
    apply(3'd2, 0, 3'd0, 4'h0, 14'h0040, 3'd0, "R4");
    for (int k = 0; k < 9; k++)
      apply(3'd3, 0, 3'd0, 4'h0, 14'h1000 + 14'(k), 3'd0, "R10");
    for (int k = 0; k < 9; k++)
      apply(3'd4, 0, 3'd0, 4'h0, 14'h0000, 3'd0, "R10");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      apply(op, 1'($urandom), 3'($urandom), 4'($urandom),
            14'($urandom), 3'($urandom), "");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule